// File: doc/BRIEF.md
# Hashed Shadow Register Bank

This block is a small bank of shadow registers that sits next to a processor core's register file. When an instruction writes back, its result can also be placed in the bank. Custom-instruction logic then takes operands from the bank, beyond the two that it reads from the core file. Each write-back carries one copy/skip bit. The bank entry that receives a copied result is not encoded in the instruction. A lookup table indexed by the destination core register number picks it, and software can reprogram that table.

After reset the table holds a direct mapping: core register `i` lands in entry `i mod NUM_SLOTS`. Several core registers therefore share one entry, and a later copy to an entry replaces whatever that entry held. A per-write-back legacy select switches to an explicit 2-bit target code. In that mode the hash table and the copy bit play no part. Custom logic reads the bank through several independent read ports. A written value appears on those ports from the cycle after the write.

Top module: `hashed_shadow_bank`

## Requirements
- R1: While `rst_ni` is low, every bank entry is cleared to zero and hash-table entry `i` is loaded with `i mod NUM_SLOTS`.
- R2: In hash mode (`wb_legacy_i`=0), a cycle with `wb_valid_i`=1 and `wb_copy_i`=1 writes `wb_data_i` into the entry that the table holds for `wb_rd_i`. The value is readable on every read port from the next cycle.
- R3: In hash mode, a cycle with `wb_valid_i`=0 or with `wb_copy_i`=0 leaves every bank entry unchanged.
- R4: The mapping is many-to-one. With the reset table, core registers `i` and `i+NUM_SLOTS` hit the same entry, and the later copy overwrites the earlier one.
- R5: A table write (`cfg_we_i`=1) stores `cfg_slot_i` for core register `cfg_idx_i` at the clock edge. Later hash-mode copies from that register land in the new entry. A table write whose slot value is `NUM_SLOTS` or more is ignored.
- R6: When a table write and a hash-mode copy happen in the same cycle, the copy uses the mapping from before the table write.
- R7: In legacy mode (`wb_legacy_i`=1) with `wb_valid_i`=1, `wb_code_i` values 2'b00, 2'b01 and 2'b10 write entries 0, 1 and 2, and 2'b11 writes nothing. The copy bit and the hash table are ignored in this mode, and a code naming an entry of `NUM_SLOTS` or more writes nothing.
- R8: Read port `p` returns the entry selected by `rd_sel_i[p*SLOT_W +: SLOT_W]`, or zero for a select of `NUM_SLOTS` or more. During the cycle in which an entry is being written, the port still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_valid_i | input | 1 | Write-back result present this cycle |
| wb_rd_i | input | IDX_W (5) | Destination core register number |
| wb_data_i | input | DATA_W | Write-back result |
| wb_copy_i | input | 1 | Copy/skip bit, 1 = copy into bank (hash mode) |
| wb_legacy_i | input | 1 | 1 = take the target from `wb_code_i` |
| wb_code_i | input | 2 | Explicit target code for legacy mode |
| cfg_we_i | input | 1 | Hash table write strobe |
| cfg_idx_i | input | IDX_W (5) | Core register number whose mapping is written |
| cfg_slot_i | input | SLOT_W | New bank entry for that register |
| rd_sel_i | input | NUM_RD*SLOT_W | Packed entry selects, one per read port |
| rd_data_o | output | NUM_RD*DATA_W | Packed read data, one word per read port |

## Verification
A table rewrite and a write-back copy can fall in the same cycle, and the copy must resolve through the old mapping. The bench provokes this by rewriting the mapping of the register it is copying from in that very cycle, and also at random. It checks the bank afterwards against a model that applies the copy before it updates its table copy. A write and a read of the same entry can also coincide. That case is judged by sampling the read port before the clock edge and expecting the old value.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam logic [1:0] LEGACY_SKIP = 2'b11;

  function automatic int slot_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/shadow_hash_table.sv
module shadow_hash_table #(
  parameter int CORE_REGS = 32,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 5,
  parameter int SLOT_W    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [IDX_W-1:0]            cfg_idx_i,
  input  logic [SLOT_W-1:0]           cfg_slot_i,
  input  logic [IDX_W-1:0]            look_idx_i,
  output logic [SLOT_W-1:0]           look_slot_o,
  output logic [CORE_REGS*SLOT_W-1:0] tbl_flat_o
);
  localparam logic [SLOT_W:0] SLOT_LIM = NUM_SLOTS[SLOT_W:0];

  logic [SLOT_W-1:0] tbl_q [CORE_REGS];
  logic              cfg_ok;

  assign cfg_ok = cfg_we_i && ({1'b0, cfg_slot_i} < SLOT_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CORE_REGS; i++) tbl_q[i] <= SLOT_W'(i % NUM_SLOTS);
    end else if (cfg_ok) begin
      for (int i = 0; i < CORE_REGS; i++)
        if (cfg_idx_i == IDX_W'(i)) tbl_q[i] <= cfg_slot_i;
    end
  end

  // lookup reads the registered table: a same-cycle rewrite is not seen
  always_comb begin
    look_slot_o = '0;
    for (int i = 0; i < CORE_REGS; i++)
      if (look_idx_i == IDX_W'(i)) look_slot_o = tbl_q[i];
  end

  for (genvar g = 0; g < CORE_REGS; g++) begin : g_flat
    assign tbl_flat_o[g*SLOT_W +: SLOT_W] = tbl_q[g];
  end
endmodule

// File: rtl/shadow_target_sel.sv
module shadow_target_sel
  import shadow_bank_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic              wb_valid_i,
  input  logic              wb_copy_i,
  input  logic              wb_legacy_i,
  input  logic [1:0]        wb_code_i,
  input  logic [SLOT_W-1:0] hash_slot_i,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o
);
  logic code_in_range;

  assign code_in_range = ({2'b00, wb_code_i} < 4'(NUM_SLOTS));

  always_comb begin
    wr_en_o   = 1'b0;
    wr_slot_o = hash_slot_i;
    if (wb_valid_i) begin
      if (wb_legacy_i) begin
        wr_slot_o = SLOT_W'(wb_code_i);
        wr_en_o   = (wb_code_i != LEGACY_SKIP) && code_in_range;
      end else begin
        wr_en_o = wb_copy_i;
      end
    end
  end
endmodule

// File: rtl/shadow_store.sv
module shadow_store #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int DATA_W    = 32,
  parameter int NUM_RD    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SLOT_W-1:0]           wr_slot_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [NUM_RD*SLOT_W-1:0]    rd_sel_i,
  output logic [NUM_RD*DATA_W-1:0]    rd_data_o,
  output logic [NUM_SLOTS*DATA_W-1:0] bank_flat_o
);
  logic [DATA_W-1:0] bank_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      bank_q[s] <= '0;
      else if (wr_en_i && (wr_slot_i == SLOT_W'(s)))    bank_q[s] <= wr_data_i;
    end
    assign bank_flat_o[s*DATA_W +: DATA_W] = bank_q[s];
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic [SLOT_W-1:0] sel;
    logic [DATA_W-1:0] word;
    assign sel = rd_sel_i[p*SLOT_W +: SLOT_W];
    always_comb begin
      word = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
        if (sel == SLOT_W'(s)) word = bank_q[s];
    end
    assign rd_data_o[p*DATA_W +: DATA_W] = word;
  end
endmodule

// File: rtl/hashed_shadow_bank.sv
module hashed_shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int CORE_REGS = 32,
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_RD    = 2,
  localparam int IDX_W    = $clog2(CORE_REGS),
  localparam int SLOT_W   = slot_width(NUM_SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wb_valid_i,
  input  logic [IDX_W-1:0]         wb_rd_i,
  input  logic [DATA_W-1:0]        wb_data_i,
  input  logic                     wb_copy_i,
  input  logic                     wb_legacy_i,
  input  logic [1:0]               wb_code_i,
  input  logic                     cfg_we_i,
  input  logic [IDX_W-1:0]         cfg_idx_i,
  input  logic [SLOT_W-1:0]        cfg_slot_i,
  input  logic [NUM_RD*SLOT_W-1:0] rd_sel_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o
);
  logic [SLOT_W-1:0]           hash_slot;
  logic                        wr_en;
  logic [SLOT_W-1:0]           wr_slot;
  logic [CORE_REGS*SLOT_W-1:0] tbl_flat;
  logic [NUM_SLOTS*DATA_W-1:0] bank_flat;

  shadow_hash_table #(
    .CORE_REGS(CORE_REGS), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_slot_i (cfg_slot_i),
    .look_idx_i (wb_rd_i),
    .look_slot_o(hash_slot),
    .tbl_flat_o (tbl_flat)
  );

  shadow_target_sel #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_sel (
    .wb_valid_i (wb_valid_i),
    .wb_copy_i  (wb_copy_i),
    .wb_legacy_i(wb_legacy_i),
    .wb_code_i  (wb_code_i),
    .hash_slot_i(hash_slot),
    .wr_en_o    (wr_en),
    .wr_slot_o  (wr_slot)
  );

  shadow_store #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_slot_i  (wr_slot),
    .wr_data_i  (wb_data_i),
    .rd_sel_i   (rd_sel_i),
    .rd_data_o  (rd_data_o),
    .bank_flat_o(bank_flat)
  );
endmodule

// File: rtl/hashed_shadow_bank_chk.sv
module hashed_shadow_bank_chk #(
  parameter int CORE_REGS = 32,
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int SLOT_W    = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wb_valid_i,
  input logic                        wb_copy_i,
  input logic                        wb_legacy_i,
  input logic [1:0]                  wb_code_i,
  input logic [DATA_W-1:0]           wb_data_i,
  input logic                        cfg_we_i,
  input logic [IDX_W-1:0]            cfg_idx_i,
  input logic [SLOT_W-1:0]           cfg_slot_i,
  input logic [SLOT_W-1:0]           wr_slot,
  input logic [CORE_REGS*SLOT_W-1:0] tbl_flat,
  input logic [NUM_SLOTS*DATA_W-1:0] bank_flat
);
  AST_HASH_COPY_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !wb_legacy_i && wb_copy_i) |=>
      bank_flat[int'($past(wr_slot))*DATA_W +: DATA_W] == $past(wb_data_i)); // R2

  AST_SKIP_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wb_valid_i || (!wb_legacy_i && !wb_copy_i)) |=> $stable(bank_flat)); // R3

  AST_CFG_TAKES_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && ({1'b0, cfg_slot_i} < NUM_SLOTS[SLOT_W:0])) |=>
      tbl_flat[int'($past(cfg_idx_i))*SLOT_W +: SLOT_W] == $past(cfg_slot_i)); // R5

  AST_LEGACY_SKIP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_legacy_i && (wb_code_i == 2'b11)) |=> $stable(bank_flat)); // R7
endmodule

bind hashed_shadow_bank hashed_shadow_bank_chk #(
  .CORE_REGS(CORE_REGS), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wb_valid_i (wb_valid_i),
  .wb_copy_i  (wb_copy_i),
  .wb_legacy_i(wb_legacy_i),
  .wb_code_i  (wb_code_i),
  .wb_data_i  (wb_data_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_idx_i  (cfg_idx_i),
  .cfg_slot_i (cfg_slot_i),
  .wr_slot    (wr_slot),
  .tbl_flat   (tbl_flat),
  .bank_flat  (bank_flat)
);

// File: tb/sim_hashed_shadow_bank.sv
module sim_hashed_shadow_bank;
  localparam int CR = 32;
  localparam int K  = 4;
  localparam int DW = 32;
  localparam int NR = 2;
  localparam int IW = 5;
  localparam int SW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wb_valid_i = 1'b0;
  logic [IW-1:0] wb_rd_i = '0;
  logic [DW-1:0] wb_data_i = '0;
  logic          wb_copy_i = 1'b0;
  logic          wb_legacy_i = 1'b0;
  logic [1:0]    wb_code_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic [SW-1:0] cfg_slot_i = '0;
  logic [NR*SW-1:0] rd_sel_i = '0;
  logic [NR*DW-1:0] rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_bank [K];
  logic [SW-1:0] exp_tbl  [CR];

  always #5 clk_i = ~clk_i;

  hashed_shadow_bank #(.CORE_REGS(CR), .NUM_SLOTS(K), .DATA_W(DW), .NUM_RD(NR)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wb_valid_i(wb_valid_i), .wb_rd_i(wb_rd_i),
    .wb_data_i(wb_data_i), .wb_copy_i(wb_copy_i), .wb_legacy_i(wb_legacy_i),
    .wb_code_i(wb_code_i), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_slot_i(cfg_slot_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // read every entry through both ports, two entries per delta
  task automatic check_all(input string tag);
    for (int e = 0; e < K; e += 2) begin
      int e1;
      e1 = (e + 1 < K) ? e + 1 : e;
      rd_sel_i[0 +: SW]  = SW'(e);
      rd_sel_i[SW +: SW] = SW'(e1);
      #1;
      chk(tag, rd_data_o[0 +: DW], exp_bank[e]);
      chk(tag, rd_data_o[DW +: DW], exp_bank[e1]);
    end
  endtask

  function automatic bit exp_target(input bit v, input bit cp, input bit lg,
                                    input logic [1:0] code, input logic [IW-1:0] rd,
                                    output int slot);
    slot = 0;
    if (!v) return 1'b0;
    if (lg) begin
      slot = int'(code);
      return (code != 2'b11) && (slot < K);
    end
    slot = int'(exp_tbl[rd]);
    return cp;
  endfunction

  task automatic step(input bit v, input bit cp, input bit lg, input logic [1:0] code,
                      input logic [IW-1:0] rd, input logic [DW-1:0] d,
                      input bit cwe, input logic [IW-1:0] cidx, input logic [SW-1:0] cslot,
                      input bit peek);
    int  slot;
    bit  en;
    @(negedge clk_i);
    wb_valid_i = v; wb_copy_i = cp; wb_legacy_i = lg; wb_code_i = code;
    wb_rd_i = rd; wb_data_i = d; cfg_we_i = cwe; cfg_idx_i = cidx; cfg_slot_i = cslot;
    en = exp_target(v, cp, lg, code, rd, slot);
    if (peek) begin
      rd_sel_i[0 +: SW] = SW'(slot);
      #1;
      chk("R8 no bypass", rd_data_o[0 +: DW], exp_bank[slot]);
    end
    @(posedge clk_i);
    if (en) exp_bank[slot] = d;       // copy uses old mapping
    if (cwe) exp_tbl[cidx] = cslot;
    #1;
    wb_valid_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int e = 0; e < K; e++) exp_bank[e] = '0;
    for (int i = 0; i < CR; i++) exp_tbl[i] = SW'(i % K);
    repeat (3) @(posedge clk_i);
    #1;
    check_all("R1 reset clears bank");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4/R1: default table, aliasing registers overwrite
    for (int i = 0; i < CR; i++) begin
      step(1, 1, 0, 2'b00, IW'(i), 32'hA000_0000 + DW'(i), 0, '0, '0, 0);
      check_all("R4 default map overwrite");
    end

    // R3: skip bit, and invalid cycles
    step(1, 0, 0, 2'b00, 5'd3, 32'hDEAD_0001, 0, '0, '0, 0);
    check_all("R3 copy bit clear");
    step(0, 1, 0, 2'b00, 5'd2, 32'hDEAD_0002, 0, '0, '0, 0);
    check_all("R3 invalid write-back");

    // R2/R8: write visible next cycle only
    step(1, 1, 0, 2'b00, 5'd9, 32'h1234_5678, 0, '0, '0, 1);
    check_all("R2 copy lands");

    // R5: remap reg 5 from entry 1 to entry 3
    step(0, 0, 0, 2'b00, '0, '0, 1, 5'd5, 2'd3, 0);
    step(1, 1, 0, 2'b00, 5'd5, 32'h5555_0003, 0, '0, '0, 0);
    check_all("R5 remapped target");

    // R6: remap reg 6 to entry 0 in the same cycle as its copy
    step(1, 1, 0, 2'b00, 5'd6, 32'h6666_0002, 1, 5'd6, 2'd0, 0);
    check_all("R6 same-cycle old mapping");
    step(1, 1, 0, 2'b00, 5'd6, 32'h6666_0000, 0, '0, '0, 0);
    check_all("R6 new mapping afterwards");

    // R7: legacy codes, copy bit ignored
    for (int c = 0; c < 4; c++) begin
      step(1, 0, 1, 2'(c), 5'd31, 32'h7000_0000 + DW'(c), 0, '0, '0, 0);
      check_all("R7 legacy code");
    end
    step(1, 1, 1, 2'b11, 5'd0, 32'h7777_FFFF, 0, '0, '0, 0);
    check_all("R7 legacy skip with copy set");

    // random mix of all functions
    for (int n = 0; n < 500; n++) begin
      logic [1:0] code;
      bit v, cp, lg, cwe;
      v   = ($urandom % 4) != 0;
      cp  = $urandom % 2;
      lg  = ($urandom % 4) == 0;
      cwe = ($urandom % 6) == 0;
      code = 2'($urandom);
      step(v, cp, lg, code, IW'($urandom), $urandom, cwe, IW'($urandom),
           SW'($urandom % K), (n % 7) == 0);
      check_all("R2 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule